// File: doc/BRIEF.md
# Tournament Branch Direction Predictor with Hashed Global Component

This block predicts whether a conditional branch will be taken. It holds three tables of 2-bit saturating counters. A bimodal table is indexed by branch-address bits. A global table is indexed by a 12-bit history of recent resolved outcomes XORed with address bits. A chooser table, indexed the same way as the bimodal table, decides per branch which of the two component guesses to trust. A fetch stage sends a branch address and gets back, one cycle later, the final guess, both component guesses and the two table indices it used.

When the branch resolves, the execute stage sends those indices back together with the real outcome and the two component guesses. Both component counters move toward the outcome. The chooser counter moves only when exactly one component was right. The history register shifts in the outcome. Because the indices come back with the update, training reaches the same entries that served the prediction, even after the history has moved on.

The request side is valid/ready. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is waiting and `rsp_ready` is low. A waiting response is held unchanged until `rsp_ready` rises. The update port never applies back-pressure.

Top module: `tourney_pred`

## Requirements
- R1: After reset, every counter in all three tables holds 2'b10, the history register is zero and `rsp_valid` is low. A first prediction at any address is therefore taken.
- R2: The bimodal and chooser index is address bits [BIM_IDX_W+1:2]. It is returned on `rsp_bim_idx`.
- R3: Every counter is 2 bits wide and predicts taken when its MSB is 1. It steps up on a taken outcome and down on a not-taken outcome. It saturates at 2'b11 and at 2'b00.
- R4: The global index is the history register XORed with address bits [GHR_W+1:2]. It is returned on `rsp_gsh_idx`.
- R5: On each update the history register shifts left by one and the outcome enters at bit 0. Without an update the register holds its value.
- R6: The chooser entry at `upd_bim_idx` steps up when the bimodal guess matched the outcome and the global guess did not. It steps down in the opposite case. Otherwise it is unchanged.
- R7: `rsp_taken` equals `rsp_bim_taken` when the chooser MSB is 1, and equals `rsp_gsh_taken` when it is 0.
- R8: A request accepted on one clock edge shows as `rsp_valid` after that edge. The response is held stable while `rsp_ready` is low, and during that time `req_ready` is low.
- R9: `upd_ready` is always high. A bimodal update trains the entry at `upd_bim_idx` and a global update trains the entry at `upd_gsh_idx`. A request accepted on the same edge as an update sees the tables and history as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prediction request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Branch address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Final direction guess |
| rsp_bim_taken | output | 1 | Bimodal component guess |
| rsp_gsh_taken | output | 1 | Global component guess |
| rsp_bim_idx | output | BIM_IDX_W | Bimodal/chooser index used |
| rsp_gsh_idx | output | GHR_W | Global index used |
| upd_valid | input | 1 | Resolution update present |
| upd_ready | output | 1 | Always high |
| upd_bim_idx | input | BIM_IDX_W | Bimodal/chooser index from the prediction |
| upd_gsh_idx | input | GHR_W | Global index from the prediction |
| upd_taken | input | 1 | Resolved outcome |
| upd_bim_taken | input | 1 | Bimodal guess from the prediction |
| upd_gsh_taken | input | 1 | Global guess from the prediction |

## Verification
The bench uses a reduced table size and runs a long pseudo-random mix of predictions and updates. It supplies arbitrary component guesses, so all four chooser cases occur, including cases where the chooser sits at either bound. It compares every response field against a model of the counters and history kept in the bench.

Directed runs then drive counters into both bounds. A design that wraps instead of saturating would flip its guess after the bound is reached. A design that shifts history at the wrong end or at the wrong time would return the wrong global index. The bench also holds a response under back-pressure while a second request waits; a design that dropped or overwrote the response would change the held fields. Finally it issues a prediction and an update to the same entry on one edge; a design with write-first reads would return the post-update guess instead of the pre-update one.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_RESET = 2'b10;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RESET;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end

  assign rd_ctr = mem[rd_idx];

  // R3: no wrap past the upper bound
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && mem[wr_idx] == 2'b11) |=> (mem[$past(wr_idx)] == 2'b11));

  // R3: no wrap past the lower bound
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && mem[wr_idx] == 2'b00) |=> (mem[$past(wr_idx)] == 2'b00));

  // R3: a written entry moves in the requested direction
  p_step_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up) |=> (mem[$past(wr_idx)] >= $past(mem[wr_idx])));
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end

  // R5: newest outcome lands at bit 0
  p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(bit_in)));

  // R5: older bits move up one place
  p_shift_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[W-1:1] == $past(hist[W-2:0])));

  // R5: no update, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BIM_IDX_W = 10,
  parameter int GHR_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_taken,
  output logic                 rsp_bim_taken,
  output logic                 rsp_gsh_taken,
  output logic [BIM_IDX_W-1:0] rsp_bim_idx,
  output logic [GHR_W-1:0]     rsp_gsh_idx,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [BIM_IDX_W-1:0] upd_bim_idx,
  input  logic [GHR_W-1:0]     upd_gsh_idx,
  input  logic                 upd_taken,
  input  logic                 upd_bim_taken,
  input  logic                 upd_gsh_taken
);
  localparam int IDX_LSB = 2;

  logic unused_addr_bits;
  assign unused_addr_bits = ^req_addr;

  logic [GHR_W-1:0]     ghr;
  logic [BIM_IDX_W-1:0] p_bim_idx;
  logic [GHR_W-1:0]     p_gsh_idx;
  ctr2_t                bim_ctr, gsh_ctr, cho_ctr;
  logic                 accept;
  logic                 bim_ok, gsh_ok, cho_en;

  assign p_bim_idx = req_addr[IDX_LSB +: BIM_IDX_W];
  assign p_gsh_idx = ghr ^ req_addr[IDX_LSB +: GHR_W];

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign upd_ready = 1'b1;

  assign bim_ok = (upd_bim_taken == upd_taken);
  assign gsh_ok = (upd_gsh_taken == upd_taken);
  assign cho_en = upd_valid && (bim_ok != gsh_ok);

  tp_ctr_table #(.IDX_W(BIM_IDX_W)) u_bim (
    .clk(clk), .rst_n(rst_n), .rd_idx(p_bim_idx), .rd_ctr(bim_ctr),
    .wr_en(upd_valid), .wr_idx(upd_bim_idx), .wr_up(upd_taken));

  tp_ctr_table #(.IDX_W(GHR_W)) u_gsh (
    .clk(clk), .rst_n(rst_n), .rd_idx(p_gsh_idx), .rd_ctr(gsh_ctr),
    .wr_en(upd_valid), .wr_idx(upd_gsh_idx), .wr_up(upd_taken));

  tp_ctr_table #(.IDX_W(BIM_IDX_W)) u_cho (
    .clk(clk), .rst_n(rst_n), .rd_idx(p_bim_idx), .rd_ctr(cho_ctr),
    .wr_en(cho_en), .wr_idx(upd_bim_idx), .wr_up(bim_ok));

  tp_ghr #(.W(GHR_W)) u_ghr (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .bit_in(upd_taken),
    .hist(ghr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_taken     <= 1'b0;
      rsp_bim_taken <= 1'b0;
      rsp_gsh_taken <= 1'b0;
      rsp_bim_idx   <= '0;
      rsp_gsh_idx   <= '0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_bim_taken <= bim_ctr[1];
      rsp_gsh_taken <= gsh_ctr[1];
      rsp_taken     <= cho_ctr[1] ? bim_ctr[1] : gsh_ctr[1];
      rsp_bim_idx   <= p_bim_idx;
      rsp_gsh_idx   <= p_gsh_idx;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  // R8: a stalled response keeps every field
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_taken)
      && $stable(rsp_bim_idx) && $stable(rsp_gsh_idx)
      && $stable(rsp_bim_taken) && $stable(rsp_gsh_taken)));

  // R8: no new request while the response is stalled
  p_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R7: when the components agree the choice cannot matter
  p_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bim_taken == rsp_gsh_taken) |-> (rsp_taken == rsp_bim_taken));

  // R6: chooser stays put when both or neither component was right
  p_cho_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_bim_taken == upd_gsh_taken)) |-> !cho_en);

  // R9: updates are never refused
  p_upd_ready_r9: assert property (@(posedge clk) disable iff (!rst_n) upd_ready);
endmodule

// File: tb/tourney_pred_test.sv
module tourney_pred_test;
  localparam int AW = 32;
  localparam int BW = 3;
  localparam int GW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, rsp_ready = 1, upd_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_taken, rsp_bim_taken, rsp_gsh_taken, upd_ready;
  logic [BW-1:0] rsp_bim_idx;
  logic [GW-1:0] rsp_gsh_idx;
  logic [BW-1:0] upd_bim_idx = '0;
  logic [GW-1:0] upd_gsh_idx = '0;
  logic upd_taken = 0, upd_bim_taken = 0, upd_gsh_taken = 0;

  always #10 clk = ~clk;

  tourney_pred #(.ADDR_W(AW), .BIM_IDX_W(BW), .GHR_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(rsp_taken), .rsp_bim_taken(rsp_bim_taken),
    .rsp_gsh_taken(rsp_gsh_taken), .rsp_bim_idx(rsp_bim_idx),
    .rsp_gsh_idx(rsp_gsh_idx), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_bim_idx(upd_bim_idx), .upd_gsh_idx(upd_gsh_idx),
    .upd_taken(upd_taken), .upd_bim_taken(upd_bim_taken),
    .upd_gsh_taken(upd_gsh_taken));

  int checks = 0, errors = 0;
  int mb [8];
  int mg [16];
  int mc [8];
  int ghr = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit done = 0;

  // expected response fields
  int e_bi, e_gi, e_bp, e_gp, e_fp;

  function automatic int step(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_for(input logic [31:0] a);
    e_bi = int'(a[4:2]);
    e_gi = (ghr ^ int'(a[5:2])) & 15;
    e_bp = mb[e_bi] / 2;
    e_gp = mg[e_gi] / 2;
    e_fp = (mc[e_bi] / 2 == 1) ? e_bp : e_gp;
  endtask

  task automatic chk_rsp(input string ctx);
    chk({ctx, " R8 rsp_valid"}, int'(rsp_valid), 1);
    chk({ctx, " R2 bim_idx"}, int'(rsp_bim_idx), e_bi);
    chk({ctx, " R4 R5 gsh_idx"}, int'(rsp_gsh_idx), e_gi);
    chk({ctx, " R3 bim_taken"}, int'(rsp_bim_taken), e_bp);
    chk({ctx, " R3 gsh_taken"}, int'(rsp_gsh_taken), e_gp);
    chk({ctx, " R7 taken"}, int'(rsp_taken), e_fp);
  endtask

  task automatic model_upd(input int bi, input int gi, input bit t, input bit bp, input bit gp);
    mb[bi] = step(mb[bi], t);
    mg[gi] = step(mg[gi], t);
    if ((bp == t) != (gp == t)) mc[bi] = step(mc[bi], bp == t);
    ghr = ((ghr << 1) | int'(t)) & 15;
  endtask

  task automatic do_predict(input logic [31:0] a, input string ctx);
    expect_for(a);
    @(negedge clk);
    req_valid = 1; req_addr = a; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk_rsp(ctx);
  endtask

  task automatic do_update(input int bi, input int gi, input bit t, input bit bp, input bit gp);
    @(negedge clk);
    upd_valid = 1; upd_bim_idx = BW'(bi); upd_gsh_idx = GW'(gi);
    upd_taken = t; upd_bim_taken = bp; upd_gsh_taken = gp;
    @(negedge clk);
    upd_valid = 0;
    chk("R9 upd_ready", int'(upd_ready), 1);
    model_upd(bi, gi, t, bp, gp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mb[i]) mb[i] = 2;
    foreach (mg[i]) mg[i] = 2;
    foreach (mc[i]) mc[i] = 2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 R8 req_ready after reset", int'(req_ready), 1);
    for (int i = 0; i < 8; i++) begin
      do_predict(32'(i * 4 + 32'h40), "R1 reset sweep");
      chk("R1 taken after reset", int'(rsp_taken), 1);
    end

    // R3 saturation at the top, then at the bottom, on one entry
    for (int k = 0; k < 5; k++) do_update(1, 1, 1'b1, 1'b1, 1'b0);
    do_predict(32'h0000_0004, "R3 sat high");
    for (int k = 0; k < 6; k++) do_update(1, 5, 1'b0, 1'b1, 1'b0);
    do_predict(32'h0000_0004, "R3 R6 sat low");
    for (int k = 0; k < 6; k++) do_update(1, 5, 1'b0, 1'b0, 1'b1);
    do_predict(32'h0000_0004, "R6 chooser up");

    // R5 history walk: address 0 makes the global index equal the history
    for (int k = 0; k < 6; k++) begin
      do_update(0, 0, bit'(k % 2), 1'b0, 1'b0);
      do_predict(32'h0, "R5 history shift");
      chk("R5 gsh_idx is history", int'(rsp_gsh_idx), ghr);
    end

    // near-exhaustive pseudo-random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] a;
      seed = nxt(seed); a = seed;
      do_predict(a, "mix");
      seed = nxt(seed);
      do_update(e_bi, e_gi, seed[16], seed[17], seed[18]);
    end

    // R8 back-pressure: hold response, second request must wait
    begin
      logic [31:0] a1;
      a1 = 32'h0000_0018;
      expect_for(a1);
      @(negedge clk);
      req_valid = 1; req_addr = a1; rsp_ready = 0;
      @(negedge clk);
      req_addr = 32'h0000_0024;
      for (int k = 0; k < 3; k++) begin
        chk_rsp("R8 held");
        chk("R8 req_ready low while stalled", int'(req_ready), 0);
        @(negedge clk);
      end
      rsp_ready = 1; req_valid = 0;
      @(negedge clk);
      chk("R8 response drained", int'(rsp_valid), 0);
    end

    // R9 predict and update on the same edge to the same entries
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      int bi, gi;
      a = 32'(k * 8 + 4);
      expect_for(a);
      bi = e_bi; gi = e_gi;
      @(negedge clk);
      req_valid = 1; req_addr = a; rsp_ready = 1;
      upd_valid = 1; upd_bim_idx = BW'(bi); upd_gsh_idx = GW'(gi);
      upd_taken = ~e_bp[0]; upd_bim_taken = e_bp[0]; upd_gsh_taken = ~e_bp[0];
      @(negedge clk);
      req_valid = 0; upd_valid = 0;
      chk_rsp("R9 same edge");
      model_upd(bi, gi, ~e_bp[0], e_bp[0], ~e_bp[0]);
      do_predict(a, "R9 after same edge");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule